// File: doc/BRIEF.md
# Serial Disk Byte Transfer Engine

This block sits between a host register bus and a one-wire serial data stream going to or coming from a disk drive. The host writes outgoing bytes into a write-data register and collects incoming bytes from a read-data register. The engine turns outgoing bytes into a bit stream and assembles incoming bits back into bytes. A 4-bit Johnson counter tracks the bit position within each byte. A byte-ready flag, and an optional interrupt, tell the host when the next byte must be serviced. A 16-bit CRC (generator x^16 + x^12 + x^5 + 1) runs over every bit that is moved. All shifting is paced by a single-cycle bit-clock enable input. Bits travel most significant bit first.

A transfer is armed by the enable bit of the control register; while that bit is clear the CRC is held at zero. In receive direction the engine first hunts for a start mark: zero bits are discarded, and the first 1 bit is folded into the CRC and begins the block. The next 8 bits form the first byte. In send direction, arming loads the write-data register at once, raises the byte-ready flag and starts shifting. Before arming, the output stays at a steady 0. At the end of a block, the CRC-emit control bit replaces the data with the CRC register itself. After 16 emitted bits that register is back at zero. A receiver that takes in the same data and the 16 CRC bits ends with a zero register, and a status bit reports this.

The controller is a four-state machine. S_IDLE is entered on reset and whenever the enable bit is clear or the direction bit changes. From S_IDLE, arming in receive direction goes to S_HUNT and arming in send direction goes to S_SEND, loading the first byte on the way. S_HUNT moves to S_RECV on the first 1 bit sampled under a bit enable. S_RECV and S_SEND stay put, raising the flag every 8 bit enables, until disarmed.

Top module: `serial_byte_xfer`

## Requirements
- R1: After reset the status register (address 2) reads 0, ser_out is 0 and irq is 0.
- R2: With control bit 0 (enable) clear, ser_out stays 0 whatever is written to the write-data register (address 0) and whatever bit enables arrive.
- R3: Writing the control register (address 1) with bit 0 set and bit 1 (direction, 1 = receive) clear makes the engine load the write-data register and raise the byte-ready flag one clock after the control register updates. ser_out then presents that byte MSB first, advancing one bit per bit_en pulse.
- R4: In send direction, every 8th bit_en reloads the write-data register into the output shifter and raises the byte-ready flag again.
- R5: In receive direction, bits sampled as 0 before the first 1 are discarded and never raise the byte-ready flag.
- R6: After the start-mark 1 bit, each group of 8 ser_in bits (MSB first) is copied to the read-data register (address 3), and the byte-ready flag is raised on the 8th bit.
- R7: The CRC (polynomial 0x1021, MSB-first, initial value 0) is updated on every transferred bit, including the start mark. It is held at 0 while control bit 0 is clear. Status bit 1 reads 1 when the CRC is nonzero and 0 when it is zero.
- R8: With control bit 2 (CRC emit) set in send direction, ser_out streams the CRC register MSB first and the write-data register is ignored. After 16 bits the CRC reads zero.
- R9: The byte-ready flag, readable as status bit 0, is cleared by a write to address 0 or by a read of address 2 or 3. A same-cycle raise takes precedence.
- R10: irq is high exactly while the byte-ready flag is set and control bit 3 (interrupt enable) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 2 | Register address: 0 write data, 1 control, 2 status, 3 read data |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for the addressed register |
| bit_en | input | 1 | One-cycle serial bit-clock enable |
| ser_in | input | 1 | Serial data from the drive |
| ser_out | output | 1 | Serial data to the drive |
| irq | output | 1 | Byte-ready interrupt |

## Verification
Send transfers use random byte blocks followed by an emitted CRC. The bench compares the captured serial stream against bench-computed bytes and CRC, which separates wrong bit order, wrong reload timing and a wrong polynomial. Receive transfers start with a random-length run of zeros before the start mark, which shows whether leading zeros are really discarded and whether the mark is included in the CRC. A block ending with a correct CRC and a block ending with a single flipped CRC bit must give opposite values of the zero-CRC status bit. A disarmed send with bit pulses and a pass with interrupts masked show that idle output and interrupt gating are kept apart from the flag itself.

// File: rtl/sx_pkg.sv
package sx_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HUNT = 2'd1,
        S_RECV = 2'd2,
        S_SEND = 2'd3
    } sx_state_t;

    typedef struct packed {
        logic irq_en;
        logic crc_out;
        logic dir_rd;
        logic en;
    } sx_ctl_t;

    localparam logic [1:0] A_WDATA = 2'd0;
    localparam logic [1:0] A_CTRL  = 2'd1;
    localparam logic [1:0] A_STAT  = 2'd2;
    localparam logic [1:0] A_RDATA = 2'd3;

endpackage

// File: rtl/sx_crc_acc.sv
module sx_crc_acc #(
    parameter int               CW   = 16,
    parameter logic [CW-1:0]    POLY = 16'h1021
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic          din,
    output logic [CW-1:0] crc,
    output logic          nonzero
);
    logic fb;

    assign fb      = crc[CW-1] ^ din;
    assign nonzero = |crc;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= '0;
        end else if (step) begin
            crc <= {crc[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end
endmodule

// File: rtl/sx_johnson.sv
module sx_johnson #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic adv,
    output logic last
);
    logic [N-1:0] q;

    assign last = (q == N'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            q <= '0;
        end else if (adv) begin
            q <= {~q[0], q[N-1:1]};
        end
    end
endmodule

// File: rtl/sx_hostif.sv
module sx_hostif
    import sx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          stat_flag,
    input  logic          stat_crc_nz,
    input  logic [DW-1:0] rd_buf,
    output logic [DW-1:0] wr_data,
    output sx_ctl_t       ctl,
    output logic          flag_clr,
    output logic [DW-1:0] bus_rdata
);
    localparam int CTLW = $bits(sx_ctl_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_data <= '0;
            ctl     <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_WDATA) wr_data <= bus_wdata;
            if (bus_addr == A_CTRL)  ctl     <= sx_ctl_t'(bus_wdata[CTLW-1:0]);
        end
    end

    assign flag_clr = (bus_wr && bus_addr == A_WDATA) ||
                      (bus_rd && (bus_addr == A_STAT || bus_addr == A_RDATA));

    always_comb begin
        unique case (bus_addr)
            A_STAT:  bus_rdata = {{(DW-2){1'b0}}, stat_crc_nz, stat_flag};
            A_RDATA: bus_rdata = rd_buf;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/serial_byte_xfer.sv
module serial_byte_xfer
    import sx_pkg::*;
#(
    parameter int            DW   = 8,
    parameter int            CW   = 16,
    parameter logic [CW-1:0] POLY = 16'h1021
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          bit_en,
    input  logic          ser_in,
    output logic          ser_out,
    output logic          irq
);
    localparam int JN = DW / 2;

    sx_state_t     state_q, state_d;
    sx_ctl_t       ctl;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] txsr;
    logic [DW-2:0] rxsr;
    logic [DW-1:0] rd_buf;
    logic [CW-1:0] crc_q;
    logic          crc_nz;
    logic          flag_q, flag_clr;
    logic          jc_last, jc_restart, jc_adv;
    logic          tx_load, tx_shift, rx_shift, rx_commit, byte_evt;
    logic          crc_step, crc_din, tx_bit, out_c, abort;

    sx_hostif #(.DW(DW)) u_host (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata),
        .stat_flag(flag_q), .stat_crc_nz(crc_nz), .rd_buf(rd_buf),
        .wr_data(wr_data), .ctl(ctl), .flag_clr(flag_clr),
        .bus_rdata(bus_rdata)
    );

    sx_crc_acc #(.CW(CW), .POLY(POLY)) u_crc (
        .clk(clk), .rst(rst), .clr(!ctl.en),
        .step(crc_step), .din(crc_din),
        .crc(crc_q), .nonzero(crc_nz)
    );

    sx_johnson #(.N(JN)) u_bitpos (
        .clk(clk), .rst(rst),
        .restart(jc_restart), .adv(jc_adv), .last(jc_last)
    );

    assign tx_bit = ctl.crc_out ? crc_q[CW-1] : txsr[DW-1];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Next state and datapath strobes
    always_comb begin
        state_d    = state_q;
        jc_restart = 1'b0;
        jc_adv     = 1'b0;
        tx_load    = 1'b0;
        tx_shift   = 1'b0;
        rx_shift   = 1'b0;
        rx_commit  = 1'b0;
        byte_evt   = 1'b0;
        crc_step   = 1'b0;
        crc_din    = 1'b0;
        out_c      = 1'b0;
        abort      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                jc_restart = 1'b1;
                if (ctl.en) begin
                    if (ctl.dir_rd) begin
                        state_d = S_HUNT;
                    end else begin
                        state_d  = S_SEND;
                        tx_load  = 1'b1;
                        byte_evt = 1'b1;
                    end
                end
            end
            S_HUNT: begin
                abort = !ctl.en || !ctl.dir_rd;
                if (abort) begin
                    state_d = S_IDLE;
                end else if (bit_en && ser_in) begin
                    state_d    = S_RECV;
                    crc_step   = 1'b1;
                    crc_din    = 1'b1;
                    jc_restart = 1'b1;
                end
            end
            S_RECV: begin
                abort = !ctl.en || !ctl.dir_rd;
                if (abort) begin
                    state_d = S_IDLE;
                end else if (bit_en) begin
                    rx_shift = 1'b1;
                    crc_step = 1'b1;
                    crc_din  = ser_in;
                    jc_adv   = 1'b1;
                    if (jc_last) begin
                        rx_commit = 1'b1;
                        byte_evt  = 1'b1;
                    end
                end
            end
            S_SEND: begin
                abort = !ctl.en || ctl.dir_rd;
                if (abort) begin
                    state_d = S_IDLE;
                end else begin
                    out_c = tx_bit;
                    if (bit_en) begin
                        crc_step = 1'b1;
                        crc_din  = tx_bit;
                        jc_adv   = 1'b1;
                        if (jc_last) begin
                            tx_load  = 1'b1;
                            byte_evt = 1'b1;
                        end else begin
                            tx_shift = 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    // Shifters and read buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            txsr   <= '0;
            rxsr   <= '0;
            rd_buf <= '0;
        end else begin
            if (tx_load)       txsr <= wr_data;
            else if (tx_shift) txsr <= {txsr[DW-2:0], 1'b0};
            if (rx_shift)      rxsr <= {rxsr[DW-3:0], ser_in};
            if (rx_commit)     rd_buf <= {rxsr, ser_in};
        end
    end

    // Byte-ready flag: raise wins over clear
    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (byte_evt) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign ser_out = out_c;
    assign irq     = flag_q && ctl.irq_en;
endmodule

// File: rtl/sx_xfer_chk.sv
module sx_xfer_chk
    import sx_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ctl_en,
    input logic          ctl_dir,
    input logic          ctl_crc_out,
    input logic          ctl_irq_en,
    input sx_state_t     state,
    input logic          flag,
    input logic          irq,
    input logic          ser_out,
    input logic          bit_en,
    input logic [CW-1:0] crc
);
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !ctl_irq_en |-> !irq);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && !$past(ctl_en)) |-> !ser_out);

    p_crc_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> (crc == '0));

    p_crc_emit_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_SEND && ctl_en && !ctl_dir && ctl_crc_out && bit_en)
        |=> (crc == {$past(crc[CW-2:0]), 1'b0}));

    p_hunt_no_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_HUNT && !flag) |=> !flag);

    p_send_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && ctl_en && !ctl_dir) |=> (state == S_SEND && flag));
endmodule

bind serial_byte_xfer sx_xfer_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst),
    .ctl_en(ctl.en), .ctl_dir(ctl.dir_rd),
    .ctl_crc_out(ctl.crc_out), .ctl_irq_en(ctl.irq_en),
    .state(state_q), .flag(flag_q), .irq(irq),
    .ser_out(ser_out), .bit_en(bit_en), .crc(crc_q)
);

// File: tb/sim_serial_byte_xfer.sv
module sim_serial_byte_xfer;
    localparam int CLK_P = 10;
    localparam int NB    = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       bit_en = 1'b0, ser_in = 1'b0;
    logic       ser_out, irq;

    int n_chk = 0;
    int n_fail = 0;

    serial_byte_xfer u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bit_en(bit_en), .ser_in(ser_in), .ser_out(ser_out), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bit_step(input logic b, output logic o);
        ser_in = b; bit_en = 1'b1;
        #1 o = ser_out;
        @(negedge clk);
        bit_en = 1'b0; ser_in = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  d, cap, bytes [NB];
        logic [15:0] crc, cap16;
        logic        o;
        int          seed;
        seed = $urandom(32'd20240611);

        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        bus_read(2'd2, d);
        chk("R1 status", d, 8'h00);
        chk("R1 ser_out", ser_out, 1'b0);
        chk("R1 irq", irq, 1'b0);

        // R2 disarmed send: output stays zero
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'h08);
        cap = 8'h00;
        for (int i = 0; i < 8; i++) begin
            bit_step(1'b1, o);
            cap = {cap[6:0], o};
        end
        chk("R2 idle out", cap, 8'h00);
        chk("R2 idle irq", irq, 1'b0);

        // Send rounds with random data
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < NB; k++) bytes[k] = 8'($urandom);
            crc = 16'h0000;
            bus_write(2'd0, bytes[0]);
            bus_write(2'd1, 8'h09);
            tick();
            chk("R3 flag on arm", irq, 1'b1);
            chk("R3 first bit", ser_out, bytes[0][7]);
            for (int k = 0; k < NB; k++) begin
                bus_write(2'd0, (k + 1 < NB) ? bytes[k+1] : 8'hA5);
                chk("R9 wdata write clears", irq, 1'b0);
                cap = 8'h00;
                for (int i = 0; i < 8; i++) begin
                    bit_step(1'b0, o);
                    cap = {cap[6:0], o};
                    crc = crc_upd(crc, o);
                end
                chk("R3 R4 sent byte", cap, bytes[k]);
                chk("R4 flag per byte", irq, 1'b1);
            end
            bus_write(2'd1, 8'h0D);
            bus_write(2'd0, 8'hFF);
            cap16 = 16'h0000;
            for (int i = 0; i < 16; i++) begin
                bit_step(1'b0, o);
                cap16 = {cap16[14:0], o};
            end
            chk("R8 emitted crc", cap16, crc);
            bus_read(2'd2, d);
            chk("R8 R7 crc zero after emit", d[1], 1'b0);
            chk("R9 status read clears", irq, 1'b0);
            bus_write(2'd1, 8'h00);
            tick();
        end

        // Receive rounds
        for (int r = 0; r < 2; r++) begin
            int lead;
            for (int k = 0; k < NB; k++) bytes[k] = 8'($urandom);
            lead = 3 + int'($urandom % 10);
            bus_write(2'd1, 8'h0B);
            tick();
            for (int i = 0; i < lead; i++) bit_step(1'b0, o);
            chk("R5 no flag before mark", irq, 1'b0);
            crc = crc_upd(16'h0000, 1'b1);
            bit_step(1'b1, o);
            chk("R5 no flag on mark", irq, 1'b0);
            for (int k = 0; k < NB; k++) begin
                for (int i = 7; i >= 0; i--) begin
                    bit_step(bytes[k][i], o);
                    crc = crc_upd(crc, bytes[k][i]);
                    if (i > 0) chk("R6 flag only on 8th bit", irq, 1'b0);
                end
                chk("R6 flag raised", irq, 1'b1);
                bus_read(2'd3, d);
                chk("R6 received byte", d, bytes[k]);
                chk("R9 rdata read clears", irq, 1'b0);
                if (k == 0) begin
                    bus_read(2'd2, d);
                    chk("R7 crc status mid block", d[1], (crc != 16'h0000) ? 1'b1 : 1'b0);
                end
            end
            for (int i = 15; i >= 0; i--) bit_step(crc[i], o);
            bus_read(2'd2, d);
            chk("R7 crc good", d[1], 1'b0);
            bus_write(2'd1, 8'h00);
            tick();
        end

        // Corrupted CRC, interrupts masked
        bus_read(2'd2, d);
        chk("R7 crc held zero when disarmed", d[1], 1'b0);
        bus_write(2'd1, 8'h03);
        tick();
        bit_step(1'b0, o);
        bit_step(1'b1, o);
        crc = crc_upd(16'h0000, 1'b1);
        for (int i = 7; i >= 0; i--) begin
            bit_step(1'(8'h3C >> i), o);
            crc = crc_upd(crc, 1'(8'h3C >> i));
        end
        chk("R10 irq masked", irq, 1'b0);
        bus_read(2'd2, d);
        chk("R10 R9 flag visible in status", d[0], 1'b1);
        bus_read(2'd2, d);
        chk("R9 flag cleared by status read", d[0], 1'b0);
        crc[0] = ~crc[0];
        for (int i = 15; i >= 0; i--) bit_step(crc[i], o);
        bus_read(2'd2, d);
        chk("R7 crc bad", d[1], 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule